// File: doc/BRIEF.md
# Clock Source Mode Controller

This block selects the operating mode of an on-chip clock generator that can run a frequency-locked loop (FLL) from an internal or an external reference, or bypass the FLL. It combines four inputs into one mode: the reference in actual use, a 2-bit source select, a debug-enable qualifier and a low-power request. It also handles a stop request. Entering stop saves the active mode, and leaving stop restores exactly that mode. An asynchronous reset at any time, including during stop, returns the block to the internal FLL-engaged mode.

A request to change the reference can be made at any time. The reported reference status follows only when the oscillator side signals completion with a handshake pulse. Mode decoding uses this completed reference status. The block drives the FLL enable. It also drives a lock indication, which must be re-earned after every completed reference switch. A debug clock is produced by dividing the block clock (the oscillator output) by two. This clock is gated off in the low-power bypass modes and in stop.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, mode_o = 7'b0000001 (FLL engaged internal), ref_st_o = 1, fll_en_o = 1, dbg_clk_en_o = 1 and lock_o = 0.
- R2: mode_o is one-hot with bit order 0 engaged-internal, 1 engaged-external, 2 bypass-internal, 3 bypass-internal-low-power, 4 bypass-external, 5 bypass-external-low-power, 6 stop. With clk_sel_i = 2'b00, a completed reference of 1 selects bit 0 and a completed reference of 0 selects bit 1.
- R3: With a completed reference of 1 and clk_sel_i = 2'b01, the block selects bit 3 when dbg_en_i = 0 and lp_i = 1. It selects bit 2 otherwise.
- R4: With a completed reference of 0 and clk_sel_i = 2'b10, the block selects bit 5 when dbg_en_i = 0 and lp_i = 1. It selects bit 4 otherwise.
- R5: clk_sel_i = 2'b11 leaves the mode unchanged. So do the unlisted pairs (completed reference 1 with 2'b10, and completed reference 0 with 2'b01).
- R6: stop_i = 1 moves the block from any mode to stop (bit 6) at the next clock edge.
- R7: At the first edge where stop_i is low, the block leaves stop and returns to the mode that was active before stop. This holds regardless of what the other inputs did during stop. A reset during stop gives engaged-internal instead.
- R8: ref_st_o takes the value of ref_sel_i only at an edge where ref_done_i = 1 and ref_sel_i differs from ref_st_o. It never changes while the block is in stop.
- R9: lock_o rises once fll_lock_i has been high for LOCK_WAIT consecutive edges while the FLL is enabled. It drops at the edge where a reference switch completes, and at any edge where fll_lock_i is low.
- R10: dbg_clk_en_o is 0 in both low-power bypass modes and in stop, and 1 otherwise. While it is 1, dbg_clk_o toggles at every edge. While it is 0, dbg_clk_o is held at 0.
- R11: fll_en_o is 0 in both low-power bypass modes and in stop, and 1 in every other mode.
- R12: Exactly one bit of mode_o is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (oscillator output) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_sel_i | input | 1 | Requested reference: 1 internal, 0 external |
| clk_sel_i | input | 2 | Source select field |
| dbg_en_i | input | 1 | Debug enabled qualifier |
| lp_i | input | 1 | Low-power request |
| stop_i | input | 1 | Stop request |
| ref_done_i | input | 1 | Reference switch completed handshake |
| fll_lock_i | input | 1 | Raw lock flag from the FLL |
| mode_o | output | 7 | One-hot active mode |
| ref_st_o | output | 1 | Completed reference status |
| fll_en_o | output | 1 | FLL enable |
| lock_o | output | 1 | Qualified FLL lock |
| dbg_clk_en_o | output | 1 | Debug clock enable |
| dbg_clk_o | output | 1 | Divided-by-two debug clock |

## Verification
The bench builds the block with LOCK_WAIT = 4. This makes the relock window short enough to check the exact edge where lock_o rises, both after reset and after each reference switch. It sweeps every combination of reference, source select, debug qualifier and low-power bit, 32 in all. From each mode reached in the sweep, it enters stop, disturbs every input and fires an ignored handshake, then checks that the exact prior mode comes back. A separate case resets the block in the middle of stop.

// File: rtl/clk_mode_pkg.sv
`timescale 1ns/1ps
package clk_mode_pkg;
  localparam int NUM_MODES = 7;
  localparam int M_FEI   = 0;
  localparam int M_FEE   = 1;
  localparam int M_FBI   = 2;
  localparam int M_FBILP = 3;
  localparam int M_FBE   = 4;
  localparam int M_FBELP = 5;
  localparam int M_STOP  = 6;

  typedef logic [NUM_MODES-1:0] mode_oh_t;

  typedef enum logic [1:0] {
    SEL_ENGAGED  = 2'b00,
    SEL_BYP_INT  = 2'b01,
    SEL_BYP_EXT  = 2'b10,
    SEL_RESERVED = 2'b11
  } clk_sel_e;

  function automatic mode_oh_t oh(input int idx);
    mode_oh_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clk_mode_decode.sv
`timescale 1ns/1ps
module clk_mode_decode
  import clk_mode_pkg::*;
(
  input  logic     ref_st_i,
  input  logic [1:0] clk_sel_i,
  input  logic     dbg_en_i,
  input  logic     lp_i,
  output logic     valid_o,
  output mode_oh_t mode_o
);
  logic lp_gate;
  assign lp_gate = lp_i & ~dbg_en_i;

  always_comb begin
    valid_o = 1'b0;
    mode_o  = oh(M_FEI);
    unique case (clk_sel_e'(clk_sel_i))
      SEL_ENGAGED: begin
        valid_o = 1'b1;
        mode_o  = ref_st_i ? oh(M_FEI) : oh(M_FEE);
      end
      SEL_BYP_INT: begin
        valid_o = ref_st_i;
        mode_o  = lp_gate ? oh(M_FBILP) : oh(M_FBI);
      end
      SEL_BYP_EXT: begin
        valid_o = ~ref_st_i;
        mode_o  = lp_gate ? oh(M_FBELP) : oh(M_FBE);
      end
      default: begin
        valid_o = 1'b0;
        mode_o  = oh(M_FEI);
      end
    endcase
  end

  always_comb begin
    if (valid_o) a_r12_dec_onehot: assert ($countones(mode_o) == 1);
  end
endmodule

// File: rtl/clk_ref_track.sv
`timescale 1ns/1ps
module clk_ref_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_sel_i,
  input  logic ref_done_i,
  input  logic frozen_i,
  output logic ref_st_o,
  output logic switch_o
);
  logic ref_st_q;

  assign switch_o = ref_done_i & (ref_sel_i != ref_st_q) & ~frozen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_st_q <= 1'b1;
    else if (switch_o) ref_st_q <= ref_sel_i;
  end

  assign ref_st_o = ref_st_q;

  a_r8_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_done_i |=> $stable(ref_st_o));
  a_r8_ref_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |=> $stable(ref_st_o));
endmodule

// File: rtl/clk_lock_mon.sv
`timescale 1ns/1ps
module clk_lock_mon #(
  parameter int LOCK_WAIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fll_en_i,
  input  logic fll_lock_i,
  input  logic switch_i,
  output logic lock_o
);
  localparam int CW = $clog2(LOCK_WAIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_WAIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (!fll_en_i || !fll_lock_i || switch_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)                 cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = (cnt_q == CNT_MAX);

  a_r9_relock_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_i |=> !lock_o);
  a_r9_drop_on_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fll_lock_i |=> !lock_o);
endmodule

// File: rtl/clk_dbg_div.sv
`timescale 1ns/1ps
module clk_dbg_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic div_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= 1'b0;
    else if (en_i) div_q <= ~div_q;
    else           div_q <= 1'b0;
  end

  assign div_o = div_q;

  a_r10_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (div_o != $past(div_o)));
  a_r10_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !div_o);
endmodule

// File: rtl/clk_mode_ctrl.sv
`timescale 1ns/1ps
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int LOCK_WAIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_sel_i,
  input  logic [1:0] clk_sel_i,
  input  logic       dbg_en_i,
  input  logic       lp_i,
  input  logic       stop_i,
  input  logic       ref_done_i,
  input  logic       fll_lock_i,
  output logic [6:0] mode_o,
  output logic       ref_st_o,
  output logic       fll_en_o,
  output logic       lock_o,
  output logic       dbg_clk_en_o,
  output logic       dbg_clk_o
);
  mode_oh_t mode_q, mode_d, sav_q, dec_mode;
  logic     dec_valid, ref_st, ref_switch, in_stop, low_pwr;

  assign in_stop = mode_q[M_STOP];
  assign low_pwr = mode_q[M_FBILP] | mode_q[M_FBELP];

  clk_ref_track u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_sel_i  (ref_sel_i),
    .ref_done_i (ref_done_i),
    .frozen_i   (in_stop),
    .ref_st_o   (ref_st),
    .switch_o   (ref_switch)
  );

  clk_mode_decode u_dec (
    .ref_st_i  (ref_st),
    .clk_sel_i (clk_sel_i),
    .dbg_en_i  (dbg_en_i),
    .lp_i      (lp_i),
    .valid_o   (dec_valid),
    .mode_o    (dec_mode)
  );

  always_comb begin
    if (in_stop)        mode_d = stop_i ? mode_q : sav_q;
    else if (stop_i)    mode_d = oh(M_STOP);
    else if (dec_valid) mode_d = dec_mode;
    else                mode_d = mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= oh(M_FEI);
      sav_q  <= oh(M_FEI);
    end else begin
      mode_q <= mode_d;
      if (!in_stop && stop_i) sav_q <= mode_q;
    end
  end

  assign fll_en_o     = ~(low_pwr | in_stop);
  assign dbg_clk_en_o = ~(low_pwr | in_stop);

  clk_lock_mon #(.LOCK_WAIT(LOCK_WAIT)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fll_en_i   (fll_en_o),
    .fll_lock_i (fll_lock_i),
    .switch_i   (ref_switch),
    .lock_o     (lock_o)
  );

  clk_dbg_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dbg_clk_en_o),
    .div_o  (dbg_clk_o)
  );

  assign mode_o   = mode_q;
  assign ref_st_o = ref_st;

  a_r12_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);
  a_r6_enter_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> mode_o[M_STOP]);
  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[M_STOP] && !stop_i) |=> (mode_o == $past(sav_q)));
  a_r7_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o[M_STOP] && stop_i) |=> (sav_q == $past(mode_o)));
  a_r11_fll_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[M_STOP] || mode_o[M_FBILP] || mode_o[M_FBELP]) |-> !fll_en_o);
  a_r10_dbg_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[M_FBILP] || mode_o[M_FBELP]) |-> !dbg_clk_en_o);
  a_r5_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !mode_o[M_STOP] && clk_sel_i == 2'b11) |=> $stable(mode_o));
endmodule

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
  localparam int LW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_sel = 1'b1;
  logic [1:0] clk_sel = 2'b00;
  logic       dbg_en = 1'b0;
  logic       lp = 1'b0;
  logic       stop = 1'b0;
  logic       ref_done = 1'b0;
  logic       fll_lock = 1'b1;
  logic [6:0] mode;
  logic       ref_st, fll_en, lock, dbg_ce, dbg_clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clk_mode_ctrl #(.LOCK_WAIT(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_sel_i(ref_sel), .clk_sel_i(clk_sel),
    .dbg_en_i(dbg_en), .lp_i(lp), .stop_i(stop), .ref_done_i(ref_done),
    .fll_lock_i(fll_lock), .mode_o(mode), .ref_st_o(ref_st), .fll_en_o(fll_en),
    .lock_o(lock), .dbg_clk_en_o(dbg_ce), .dbg_clk_o(dbg_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // returns -1 when the combination keeps the current mode
  function automatic int model_idx(input bit r, input int c, input bit d, input bit l);
    bit g;
    g = l && !d;
    if (c == 0) return r ? 0 : 1;
    if (c == 1 && r) return g ? 3 : 2;
    if (c == 2 && !r) return g ? 5 : 4;
    return -1;
  endfunction

  task automatic pulse_done();
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_idx;
    bit exp_r;
    bit lowp;
    bit s0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 mode", int'(mode), 1);
    chk("R1 ref_st", int'(ref_st), 1);
    chk("R1 fll_en", int'(fll_en), 1);
    chk("R1 dbg_clk_en", int'(dbg_ce), 1);
    chk("R1 lock", int'(lock), 0);
    // R9 lock after LW edges
    repeat (LW - 1) @(negedge clk);
    chk("R9 lock before window", int'(lock), 0);
    @(negedge clk);
    chk("R9 lock at window", int'(lock), 1);
    // R10 divider toggles in FEI
    s0 = dbg_clk;
    @(negedge clk);
    chk("R10 toggle", int'(dbg_clk), int'(!s0));
    // R9 switch clears lock, R2 engaged external
    ref_sel = 1'b0;
    pulse_done();
    chk("R9 lock cleared at switch", int'(lock), 0);
    chk("R8 ref updated", int'(ref_st), 0);
    @(negedge clk);
    chk("R2 engaged external", int'(mode), 2);
    repeat (LW - 2) @(negedge clk);
    chk("R9 relock pending", int'(lock), 0);
    @(negedge clk);
    chk("R9 relocked", int'(lock), 1);
    fll_lock = 1'b0;
    @(negedge clk);
    chk("R9 raw unlock drops", int'(lock), 0);
    fll_lock = 1'b1;
    // R8 no change without handshake
    ref_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no handshake", int'(ref_st), 0);
    ref_sel = 1'b0;

    exp_idx = 1;
    exp_r = 1'b0;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 2; d++)
          for (int l = 0; l < 2; l++) begin
            int m;
            ref_sel = r[0]; clk_sel = c[1:0]; dbg_en = d[0]; lp = l[0];
            pulse_done();
            exp_r = r[0];
            repeat (2) @(negedge clk);
            m = model_idx(exp_r, c, d[0], l[0]);
            if (m >= 0) exp_idx = m;
            lowp = (exp_idx == 3) || (exp_idx == 5);
            if (m < 0) chk("R5 hold", int'(mode), 1 << exp_idx);
            else if (c == 0) chk("R2 engaged", int'(mode), 1 << exp_idx);
            else if (c == 1) chk("R3 bypass internal", int'(mode), 1 << exp_idx);
            else chk("R4 bypass external", int'(mode), 1 << exp_idx);
            chk("R8 ref status", int'(ref_st), int'(exp_r));
            chk("R11 fll_en", int'(fll_en), int'(!lowp));
            chk("R10 dbg_clk_en", int'(dbg_ce), int'(!lowp));
            s0 = dbg_clk;
            @(negedge clk);
            if (lowp) chk("R10 gated low", int'(dbg_clk) + int'(s0), 0);
            else chk("R10 divide", int'(dbg_clk), int'(!s0));
            chk("R12 onehot", $countones(mode), 1);
            // stop and restore
            stop = 1'b1;
            @(negedge clk);
            chk("R6 stop entered", int'(mode), 64);
            chk("R11 fll off in stop", int'(fll_en), 0);
            chk("R10 dbg off in stop", int'(dbg_ce), 0);
            clk_sel = ~c[1:0]; lp = ~l[0]; dbg_en = ~d[0]; ref_sel = ~r[0];
            pulse_done();
            chk("R8 frozen in stop", int'(ref_st), int'(exp_r));
            stop = 1'b0;
            @(negedge clk);
            chk("R7 restore prior", int'(mode), 1 << exp_idx);
            ref_sel = r[0]; clk_sel = c[1:0]; dbg_en = d[0]; lp = l[0];
            @(negedge clk);
          end

    // R7 reset during stop
    ref_sel = 1'b0; clk_sel = 2'b10; dbg_en = 1'b1; lp = 1'b0;
    pulse_done();
    repeat (2) @(negedge clk);
    chk("R4 bypass external before stop", int'(mode), 16);
    stop = 1'b1;
    @(negedge clk);
    chk("R6 stop", int'(mode), 64);
    rst_n = 1'b0;
    stop = 1'b0;
    clk_sel = 2'b00; ref_sel = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset in stop gives FEI", int'(mode), 1);
    chk("R1 ref after reset", int'(ref_st), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule